// File: doc/BRIEF.md
# Debug Halt Control Register

This block is a 32-bit debug control and status word. It has two write sources. One is an external debug probe and the other is the processor's own software bus. The word holds three control bits: a debug-enable bit, a halt request bit and a single-step bit. It drives a halt request and a one-cycle step pulse to the core, and it reads back whether the core reports itself halted.

Write permission depends on the source. The probe has full control over all three control bits. Software may set debug enable but can never clear it, and it cannot touch the halt or step bits at all. If both sources write in the same cycle, the probe write is applied and the software write is discarded.

Writes are single-cycle strobes with no back-pressure, so each write is accepted on the clock edge where its strobe is high. The read word is a combinational view of the stored bits and the halted input.

Bit layout:
- bit 0: debug enable
- bit 1: halt
- bit 2: step
- bit 17: halted status (read-only)
- every other bit reads 0

Top module: `dbg_halt_ctl`

## Requirements
- R1: After reset, the read word is 0 apart from bit 17, which follows `core_halted`. `halt_req` and `step_pulse` are 0.
- R2: A probe write stores bit 0 of its data as debug enable, so the probe can both set and clear it. The new value is visible on `rd_data` bit 0 after the clock edge.
- R3: A software write never clears debug enable. A software write with data bit 0 equal to 1 sets it.
- R4: While debug enable is 1, the halt bit (bit 1) is stored from probe data bit 1. `halt_req` is high while the halt bit is 1, except during a step pulse.
- R5: Software writes leave bits 1 (halt) and 2 (step) unchanged.
- R6: Whenever debug enable is 0, bits 1 and 2 read 0. A probe write with data bit 0 equal to 0 also clears them.
- R7: `rd_data` bit 17 always equals `core_halted`. Writing bit 17 has no effect. All bits other than 0, 1, 2 and 17 read 0.
- R8: A step is triggered when all of the following hold at the same edge:
  - a probe write has data bit 0 = 1, bit 1 = 0 and bit 2 = 1;
  - the halt bit is currently 1;
  - `core_halted` is 1.

  The step has these effects:
  - `step_pulse` is 1 for exactly the next cycle, and `halt_req` is 0 during that cycle;
  - the halt bit stays 1, so `halt_req` returns to 1 afterwards.

  Any other probe write that clears the halt bit produces no pulse.
- R9: When both ports write in the same cycle, only the probe write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_we | input | 1 | Write strobe from the external debug probe |
| probe_wdata | input | 32 | Write data from the probe |
| sw_we | input | 1 | Write strobe from the core's software bus |
| sw_wdata | input | 32 | Write data from software |
| core_halted | input | 1 | Core reports that it is halted |
| rd_data | output | 32 | Read view of the control and status word |
| halt_req | output | 1 | Halt request to the core |
| step_pulse | output | 1 | One-cycle single-step request to the core |

## Verification
The assertions check the following on every cycle:
- software never clears debug enable and never moves the halt or step bits;
- the halt and step bits read 0 whenever debug enable is 0;
- bit 17 tracks `core_halted` and the unused bits stay 0;
- `halt_req` only appears with enable and halt set;
- `step_pulse` is never longer than one cycle and only follows a probe write.

Only the bench scenarios can show the following:
- the exact value a given probe write stores;
- that the step fires for the one qualifying write pattern and not for a plain resume or a step attempted while the core runs;
- that the probe write wins when both ports collide.

// File: rtl/dbgctl_pkg.sv
package dbgctl_pkg;
  localparam int REG_W      = 32;
  localparam int BIT_EN     = 0;
  localparam int BIT_HALT   = 1;
  localparam int BIT_STEP   = 2;
  localparam int BIT_HALTED = 17;

  typedef struct packed {
    logic en;
    logic halt;
    logic step;
  } ctl_t;
endpackage

// File: rtl/dbgctl_wr_filter.sv
module dbgctl_wr_filter
  import dbgctl_pkg::*;
(
  input  ctl_t cur,
  input  logic probe_we,
  input  ctl_t probe_bits,
  input  logic sw_we,
  input  logic sw_en_bit,
  input  logic core_halted,
  output ctl_t nxt,
  output logic fire_step
);
  logic step_cond;

  // A step fires when the probe drops halt while asking for step, with the
  // core already halted and debug enable kept on.
  assign step_cond = probe_bits.en & probe_bits.step & ~probe_bits.halt &
                     cur.halt & core_halted;

  always_comb begin
    nxt       = cur;
    fire_step = 1'b0;
    if (probe_we) begin
      nxt.en   = probe_bits.en;
      nxt.halt = probe_bits.en & probe_bits.halt;
      nxt.step = probe_bits.en & probe_bits.step;
      if (step_cond) begin
        fire_step = 1'b1;
        nxt.halt  = 1'b1;
      end
    end else if (sw_we) begin
      // Software may only raise enable; halt and step are out of its reach.
      nxt.en = cur.en | sw_en_bit;
    end
  end
endmodule

// File: rtl/dbgctl_state.sv
module dbgctl_state
  import dbgctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ctl_t nxt,
  input  logic fire_step,
  output ctl_t ctl,
  output logic step_pulse,
  output logic halt_req
);
  ctl_t ctl_q;
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      ctl_q   <= nxt;
      pulse_q <= fire_step;
    end
  end

  assign ctl        = ctl_q;
  assign step_pulse = pulse_q;
  // The halt request drops for the single step cycle, then resumes.
  assign halt_req   = ctl_q.en & ctl_q.halt & ~pulse_q;
endmodule

// File: rtl/dbgctl_rdback.sv
module dbgctl_rdback
  import dbgctl_pkg::*;
#(
  parameter int W = REG_W
) (
  input  ctl_t        ctl,
  input  logic        core_halted,
  output logic [W-1:0] word
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == BIT_EN) begin : g_en
      assign word[i] = ctl.en;
    end else if (i == BIT_HALT) begin : g_halt
      assign word[i] = ctl.halt;
    end else if (i == BIT_STEP) begin : g_step
      assign word[i] = ctl.step;
    end else if (i == BIT_HALTED) begin : g_halted
      assign word[i] = core_halted;
    end else begin : g_zero
      assign word[i] = 1'b0;
    end
  end
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
  import dbgctl_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         probe_we,
  input  logic [W-1:0] probe_wdata,
  input  logic         sw_we,
  input  logic [W-1:0] sw_wdata,
  input  logic         core_halted,
  output logic [W-1:0] rd_data,
  output logic         halt_req,
  output logic         step_pulse
);
  ctl_t cur, nxt, probe_bits;
  logic fire_step;

  assign probe_bits.en   = probe_wdata[BIT_EN];
  assign probe_bits.halt = probe_wdata[BIT_HALT];
  assign probe_bits.step = probe_wdata[BIT_STEP];

  dbgctl_wr_filter u_filter (
    .cur         (cur),
    .probe_we    (probe_we),
    .probe_bits  (probe_bits),
    .sw_we       (sw_we),
    .sw_en_bit   (sw_wdata[BIT_EN]),
    .core_halted (core_halted),
    .nxt         (nxt),
    .fire_step   (fire_step)
  );

  dbgctl_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .nxt        (nxt),
    .fire_step  (fire_step),
    .ctl        (cur),
    .step_pulse (step_pulse),
    .halt_req   (halt_req)
  );

  dbgctl_rdback #(.W(W)) u_rd (
    .ctl         (cur),
    .core_halted (core_halted),
    .word        (rd_data)
  );
endmodule

// File: rtl/dbg_halt_ctl_chk.sv
module dbg_halt_ctl_chk
  import dbgctl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             probe_we,
  input logic             sw_we,
  input logic             core_halted,
  input logic [REG_W-1:0] rd_data,
  input logic             halt_req,
  input logic             step_pulse
);
  localparam logic [REG_W-1:0] USED =
    (REG_W'(1) << BIT_EN) | (REG_W'(1) << BIT_HALT) |
    (REG_W'(1) << BIT_STEP) | (REG_W'(1) << BIT_HALTED);

  p_sw_no_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !probe_we && rd_data[BIT_EN]) |=> rd_data[BIT_EN]);

  p_sw_keeps_ctl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !probe_we) |=> $stable(rd_data[BIT_STEP:BIT_HALT]));

  p_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[BIT_EN] |-> (!rd_data[BIT_HALT] && !rd_data[BIT_STEP]));

  p_halted_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[BIT_HALTED] == core_halted) && ((rd_data & ~USED) == '0));

  p_halt_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> (rd_data[BIT_EN] && rd_data[BIT_HALT] && !step_pulse));

  p_step_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |=> !step_pulse);

  p_step_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> ($past(probe_we) && rd_data[BIT_HALT] && rd_data[BIT_STEP]));
endmodule

bind dbg_halt_ctl dbg_halt_ctl_chk u_chk (.*);

// File: tb/sim_dbg_halt_ctl.sv
`timescale 1ns/1ps
module sim_dbg_halt_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        probe_we = 1'b0;
  logic [31:0] probe_wdata = '0;
  logic        sw_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic        core_halted = 1'b0;
  logic [31:0] rd_data;
  logic        halt_req;
  logic        step_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] rd;
    logic        hreq;
    logic        pulse;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  dbg_halt_ctl u0 (
    .clk(clk), .rst_n(rst_n), .probe_we(probe_we), .probe_wdata(probe_wdata),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .core_halted(core_halted),
    .rd_data(rd_data), .halt_req(halt_req), .step_pulse(step_pulse)
  );

  // Driver: applies one cycle of stimulus, then queues the expected outputs
  // seen right after that clock edge.
  task automatic op(input logic pwe, input logic [31:0] pd,
                    input logic swe, input logic [31:0] sd, input logic hlt,
                    input logic [31:0] e_rd, input logic e_h, input logic e_p,
                    input string tag);
    exp_t e;
    @(negedge clk);
    probe_we = pwe; probe_wdata = pd;
    sw_we = swe; sw_wdata = sd; core_halted = hlt;
    @(posedge clk);
    e.rd = e_rd; e.hreq = e_h; e.pulse = e_p; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: samples 2 ns after each edge, before the driver moves inputs.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (rd_data !== e.rd || halt_req !== e.hreq || step_pulse !== e.pulse) begin
          failures++;
          $display("FAIL %s: rd=%h hreq=%b pulse=%b expected rd=%h hreq=%b pulse=%b",
                   e.tag, rd_data, halt_req, step_pulse, e.rd, e.hreq, e.pulse);
        end
      end
    end
  end

  initial begin
    #1;
    checks++;
    if (rd_data !== 32'h0 || halt_req !== 1'b0 || step_pulse !== 1'b0) begin
      failures++;
      $display("FAIL R1 in reset: rd=%h hreq=%b pulse=%b expected rd=0 hreq=0 pulse=0",
               rd_data, halt_req, step_pulse);
    end
    #20 rst_n = 1'b1;
    op(0, 0, 0, 0, 0, 32'h0, 0, 0, "R1 after reset");
    op(1, 32'h1, 0, 0, 0, 32'h1, 0, 0, "R2 probe sets enable");
    op(0, 0, 1, 32'h0, 0, 32'h1, 0, 0, "R3 sw cannot clear enable");
    op(0, 0, 1, 32'h6, 0, 32'h1, 0, 0, "R5 sw cannot set halt/step");
    op(1, 32'h3, 0, 0, 0, 32'h3, 1, 0, "R4 probe sets halt");
    op(0, 0, 1, 32'h0, 0, 32'h3, 1, 0, "R5 sw cannot clear halt");
    op(0, 0, 0, 0, 1, 32'h20003, 1, 0, "R7 halted status mirrored");
    op(1, 32'h5, 0, 0, 1, 32'h20007, 0, 1, "R8 step pulse issued");
    op(0, 0, 0, 0, 1, 32'h20007, 1, 0, "R8 halt resumes after step");
    op(1, 32'h1, 0, 0, 1, 32'h20001, 0, 0, "R8 plain resume no pulse");
    op(0, 0, 0, 0, 0, 32'h1, 0, 0, "R7 halted status drops");
    op(1, 32'hFFFF_FFFF, 0, 0, 0, 32'h7, 1, 0, "R7 unused and status bits ignore writes");
    op(1, 32'h6, 0, 0, 0, 32'h0, 0, 0, "R6 disable clears halt and step");
    op(0, 0, 1, 32'h7, 0, 32'h1, 0, 0, "R3 sw sets enable only");
    op(1, 32'h0, 1, 32'h7, 0, 32'h0, 0, 0, "R9 probe clear beats sw");
    op(1, 32'h3, 1, 32'h0, 0, 32'h3, 1, 0, "R9 probe halt beats sw");
    op(1, 32'h5, 0, 0, 0, 32'h5, 0, 0, "R8 no pulse while core running");
    op(1, 32'h3, 0, 0, 1, 32'h20003, 1, 0, "R4 halt held with core halted");
    op(1, 32'h5, 1, 32'h0, 1, 32'h20007, 0, 1, "R9 R8 step with sw collision");
    op(0, 0, 0, 0, 1, 32'h20007, 1, 0, "R8 pulse lasts one cycle");
    op(0, 0, 0, 0, 0, 32'h7, 1, 0, "R4 idle hold");
    @(posedge clk);
    #3;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule